// File: doc/BRIEF.md
# Input Presence Probe Sequencer

This block decides whether the high-side power input of a synchronous buck stage is present before the converter is allowed to soft start. It does not watch a supply comparator for that input. It waits until the bias supply has cleared its power-on-reset check and the enable input is high. Then it requests short, periodic turn-on pulses for the upper switch. While it pulses, it watches a digital flag that reports whether the switch node is above its detection threshold.

The flag comes from an analog comparator and is asynchronous, so it passes through a synchroniser first. Both rising and falling transitions of the synchronised flag count as crossings. When enough crossings have been seen, the block stops pulsing and raises an input-ready flag, which starts soft start. If either the supply-good input or the enable input goes low, the block returns to its waiting state at once.

The pulse period and width are given in clock cycles. Their defaults are derived from a clock-frequency parameter: a 10 kHz probe rate and a 1 µs on-time.

Top module: `rail_probe_seq`

## Requirements
- R1: While `rstN` is low, `probeOn` and `railReady` are both 0.
- R2: `probeOn` and `railReady` are 0 in any cycle where `porGood` or `enable` is low, with no clock edge needed. A low on either input also clears the crossing count, so a later activation needs the full number of crossings again.
- R3: On the first clock edge with both `porGood` and `enable` high, probing begins. `probeOn` is then high for `PULSE_CYC` cycles out of every `PERIOD_CYC` cycles, starting with a high phase.
- R4: `swHigh` is synchronised by two flops. A crossing caused by a change of `swHigh` just before a clock edge counts at the third clock edge from that change, so `railReady` becomes visible after that edge.
- R5: Rising and falling transitions of the synchronised `swHigh` each count as one crossing. `railReady` rises when the `EDGES_NEEDED`-th crossing (default 4) counts during probing.
- R6: `probeOn` is 0 in the cycle `railReady` rises and stays 0 afterwards. While both activation inputs stay high, `railReady` holds at 1 and ignores further `swHigh` activity.
- R7: `swHigh` transitions that happen while the block is inactive are not counted.
- R8: With default parameters and `CLK_HZ` = 50,000,000, the pulse is 50 cycles high and 4950 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| porGood | input | 1 | Bias supply has passed its power-on-reset check |
| enable | input | 1 | Enable, high = run (low = shutdown) |
| swHigh | input | 1 | Asynchronous switch-node-above-threshold comparator flag |
| probeOn | output | 1 | Turn-on request for the upper switch during probing |
| railReady | output | 1 | Input supply detected; starts soft start |

## Verification
The hardest state to reach from the ports is a partial crossing count that must be thrown away. Examples are crossings that arrive while the block is disabled, or a count left at one short of the limit when an activation input drops. Directed sequences set up both cases and then show that one more crossing is not enough. Random stimulus toggles the flag at random, including inside the synchroniser window around activation. It also drops and restores the activation inputs at random, so re-entry into probing is exercised many times against a cycle-level bench model.

// File: rtl/rail_probe_pkg.sv
package rail_probe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_READY = 2'd2
  } probeState_t;

  typedef struct packed {
    logic clearAll;
    logic runTimer;
    logic countEn;
  } probeStrobe_t;

endpackage

// File: rtl/rail_probe_dp.sv
module rail_probe_dp
  import rail_probe_pkg::*;
#(
  parameter int PERIOD_CYC   = 5000,
  parameter int PULSE_CYC    = 50,
  parameter int EDGES_NEEDED = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swHigh,
  input  probeStrobe_t strobe,
  output logic         pulseWindow,
  output logic         countDone
);

  localparam int PHASE_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam int CNT_W   = $clog2(EDGES_NEEDED + 1);
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(PERIOD_CYC - 1);
  localparam logic [PHASE_W-1:0] PHASE_ON   = PHASE_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0]   CNT_LIMIT  = CNT_W'(EDGES_NEEDED);
  localparam logic [CNT_W-1:0]   CNT_PENULT = CNT_W'(EDGES_NEEDED - 1);

  // syncQ[SYNC_STAGES-1] is the synchronised flag, syncQ[SYNC_STAGES] its history
  logic [SYNC_STAGES:0] syncQ;
  logic                 edgeSeen;
  logic [PHASE_W-1:0]   phase;
  logic [CNT_W-1:0]     edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], swHigh};
  end

  assign edgeSeen = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   phase <= '0;
    else if (!strobe.runTimer)   phase <= '0;
    else if (phase == PHASE_LAST) phase <= '0;
    else                         phase <= phase + 1'b1;
  end

  assign pulseWindow = (phase < PHASE_ON);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 edgeCnt <= '0;
    else if (strobe.clearAll)  edgeCnt <= '0;
    else if (strobe.countEn && edgeSeen && (edgeCnt != CNT_LIMIT))
                               edgeCnt <= edgeCnt + 1'b1;
  end

  assign countDone = strobe.countEn && edgeSeen && (edgeCnt == CNT_PENULT);

endmodule

// File: rtl/rail_probe_ctrl.sv
module rail_probe_ctrl
  import rail_probe_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         porGood,
  input  logic         enable,
  input  logic         pulseWindow,
  input  logic         countDone,
  output probeStrobe_t strobe,
  output logic         probeOn,
  output logic         railReady
);

  probeState_t state, stateNext;
  logic        active;

  assign active = porGood & enable;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (active) stateNext = ST_PROBE;
      ST_PROBE: begin
        if (!active)        stateNext = ST_IDLE;
        else if (countDone) stateNext = ST_READY;
      end
      ST_READY: if (!active) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clearAll = (state == ST_IDLE);
    strobe.runTimer = (state == ST_PROBE);
    strobe.countEn  = (state == ST_PROBE) && active;
  end

  assign probeOn   = active && (state == ST_PROBE) && pulseWindow;
  assign railReady = active && (state == ST_READY);

endmodule

// File: rtl/rail_probe_seq.sv
module rail_probe_seq
  import rail_probe_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int PROBE_HZ     = 10_000,
  parameter int ON_TIME_NS   = 1_000,
  parameter int PERIOD_CYC   = CLK_HZ / PROBE_HZ,
  parameter int PULSE_CYC    = (CLK_HZ / 1_000_000) * ON_TIME_NS / 1_000,
  parameter int EDGES_NEEDED = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic porGood,
  input  logic enable,
  input  logic swHigh,
  output logic probeOn,
  output logic railReady
);

  localparam int SYNC_STAGES = 2;

  probeStrobe_t strobe;
  logic         pulseWindow;
  logic         countDone;

  rail_probe_dp #(
    .PERIOD_CYC  (PERIOD_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .EDGES_NEEDED(EDGES_NEEDED),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .swHigh     (swHigh),
    .strobe     (strobe),
    .pulseWindow(pulseWindow),
    .countDone  (countDone)
  );

  rail_probe_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .porGood    (porGood),
    .enable     (enable),
    .pulseWindow(pulseWindow),
    .countDone  (countDone),
    .strobe     (strobe),
    .probeOn    (probeOn),
    .railReady  (railReady)
  );

endmodule

// File: rtl/rail_probe_seq_chk.sv
module rail_probe_seq_chk #(
  parameter int PULSE_CYC = 50
) (
  input logic clk,
  input logic rstN,
  input logic porGood,
  input logic enable,
  input logic probeOn,
  input logic railReady
);

  int unsigned hiRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiRun <= 0;
    else if (probeOn) hiRun <= hiRun + 1;
    else              hiRun <= 0;
  end

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (!probeOn && !railReady); // R1
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(porGood && enable) |-> (!probeOn && !railReady)); // R2

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    hiRun <= PULSE_CYC); // R3

  AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railReady) |-> $past(porGood && enable)); // R5

  AST_NO_PROBE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !(probeOn && railReady)); // R6

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (railReady && porGood && enable) |=> (railReady || !(porGood && enable))); // R6

endmodule

bind rail_probe_seq rail_probe_seq_chk #(.PULSE_CYC(PULSE_CYC)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .porGood  (porGood),
  .enable   (enable),
  .probeOn  (probeOn),
  .railReady(railReady)
);

// File: tb/rail_probe_seq_test.sv
module rail_probe_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int PER   = 20;
  localparam int PUL   = 3;
  localparam int EDGES = 4;

  logic clk = 1'b0;
  logic rstN, porGood, enable, swHigh;
  logic probeOn, railReady;
  logic defEnable;
  logic defProbe, defReady;

  int checks = 0;
  int errors = 0;
  logic modelOn = 1'b0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_probe_seq #(.PERIOD_CYC(PER), .PULSE_CYC(PUL), .EDGES_NEEDED(EDGES)) uut (
    .clk(clk), .rstN(rstN), .porGood(porGood), .enable(enable), .swHigh(swHigh),
    .probeOn(probeOn), .railReady(railReady));

  rail_probe_seq uutDef (
    .clk(clk), .rstN(rstN), .porGood(1'b1), .enable(defEnable), .swHigh(1'b0),
    .probeOn(defProbe), .railReady(defReady));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // bench model, cycle level, built from the requirements
  int   mState;  // 0 waiting, 1 probing, 2 ready
  int   mPhase, mCnt;
  logic [2:0] mSync;

  function automatic logic expProbe(int st, int ph, logic act);
    return act && (st == 1) && (ph < PUL);
  endfunction

  function automatic logic expReady(int st, logic act);
    return act && (st == 2);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 0; mPhase <= 0; mCnt <= 0; mSync <= 3'b000;
    end else begin
      logic act, crossing;
      act = porGood && enable;
      crossing = mSync[2] ^ mSync[1];
      mSync <= {mSync[1:0], swHigh};
      case (mState)
        0: begin
          mCnt <= 0; mPhase <= 0;
          if (act) mState <= 1;
        end
        1: begin
          mPhase <= (mPhase == PER-1) ? 0 : mPhase + 1;
          if (!act) mState <= 0;
          else if (crossing) begin
            if (mCnt == EDGES-1) begin mState <= 2; mPhase <= 0; end
            mCnt <= mCnt + 1;
          end
        end
        default: begin
          mPhase <= 0;
          if (!act) mState <= 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk("R3 probeOn vs model", int'(probeOn), int'(expProbe(mState, mPhase, porGood && enable)));
      chk("R5 railReady vs model", int'(railReady), int'(expReady(mState, porGood && enable)));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic toggleSpaced(input int count, input int gap);
    for (int i = 0; i < count; i++) begin
      swHigh = ~swHigh;
      tick(gap);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    void'($urandom(32'h00C0FFEE));
    rstN = 1'b0; porGood = 1'b0; enable = 1'b0; swHigh = 1'b0; defEnable = 1'b0;
    tick(3);
    chk("R1 probeOn in reset", int'(probeOn), 0);
    chk("R1 railReady in reset", int'(railReady), 0);
    rstN = 1'b1;
    modelOn = 1'b1;

    // R2: supply good alone does not start probing
    porGood = 1'b1;
    tick(5);
    chk("R2 no probe without enable", int'(probeOn), 0);

    // R3: pulse width and period
    enable = 1'b1;
    @(negedge clk);
    hi = 0;
    while (probeOn && hi < 1000) begin hi++; @(negedge clk); end
    chk("R3 pulse width", hi, PUL);
    lo = 0;
    while (!probeOn && lo < 1000) begin lo++; @(negedge clk); end
    chk("R3 pulse gap", lo, PER - PUL);
    #1;

    // R4 R5 R6: crossings of both polarities, latency through sync
    toggleSpaced(3, 2);
    tick(2);
    swHigh = ~swHigh;
    @(negedge clk); chk("R4 ready after 1 edge", int'(railReady), 0);
    @(negedge clk); chk("R4 ready after 2 edges", int'(railReady), 0);
    @(negedge clk); chk("R5 ready after 3 edges", int'(railReady), 1);
    chk("R6 probe stops with ready", int'(probeOn), 0);
    #1;
    toggleSpaced(4, 1);
    tick(4);
    chk("R6 ready holds", int'(railReady), 1);
    chk("R6 probe stays off", int'(probeOn), 0);

    // R2: drop supply-good, outputs fall in the same cycle, count cleared
    porGood = 1'b0;
    #1;
    chk("R2 ready drops same cycle", int'(railReady), 0);
    tick(1);
    porGood = 1'b1;
    tick(1);
    toggleSpaced(3, 2);
    tick(6);
    chk("R2 count cleared after drop", int'(railReady), 0);

    // R7: crossings while disabled are ignored
    enable = 1'b0;
    tick(2);
    toggleSpaced(6, 1);
    tick(4);
    enable = 1'b1;
    tick(1);
    toggleSpaced(3, 2);
    tick(5);
    chk("R7 idle crossings ignored", int'(railReady), 0);
    swHigh = ~swHigh;
    tick(3);
    chk("R7 fourth live crossing", int'(railReady), 1);

    // random phase
    for (int c = 0; c < 20000; c++) begin
      int r;
      r = int'($urandom % 1000);
      if (r < 4)       porGood = 1'b0;
      else if (r < 8)  enable  = 1'b0;
      else if (r < 120 && !(porGood && enable)) begin porGood = 1'b1; enable = 1'b1; end
      if (($urandom % 16) == 0) swHigh = ~swHigh;
      tick(1);
    end

    // R8: default timing
    modelOn = 1'b0;
    defEnable = 1'b1;
    @(negedge clk);
    hi = 0;
    while (defProbe && hi < 10000) begin hi++; @(negedge clk); end
    chk("R8 default pulse width", hi, 50);
    lo = 0;
    while (!defProbe && lo < 10000) begin lo++; @(negedge clk); end
    chk("R8 default pulse gap", lo, 4950);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule